// File: doc/BRIEF.md
# Board-Variant Display and Card Status Registers

This block holds two bus-visible registers whose behaviour changes with the board the chip is fitted to. A 32-bit strap word is tied at integration time. A 12-bit board code taken from it selects one of five behaviours: a display-control register with a read-only identity field and a pixel-format selector output, the same register without the selector output, a register with a single writable bit, a register that reads as zero, and a fallback for codes the block does not recognise.

The second register reports two card-slot pins, card present and write protect. Both pins are resynchronised to the bus clock. The write-protect bit lands at a position that depends on the board code. Software reads and writes both registers over a simple single-cycle register bus, and read data returns one cycle after the request.

Top module: `disp_ctrl_regs`

## Requirements
- R1: The board code is bits 27:16 of `board_strap` and must match one of 0x100, 0x140, 0x178, 0x182 or 0x190 exactly. Bits outside 27:16 have no effect.
- R2: While `rst` is high, the display register loads 0x0000_1F00 (identity field 0x1F in bits 12:8) for every code except 0x190, which loads zero. `fmt_sel` clears to 0 and `bus_rvalid` clears to 0.
- R3: For code 0x100, a write to byte offset 0x50 keeps bits 13:8 of the display register and takes every other bit from the write data.
- R4: For code 0x100, a write to offset 0x50 drives `fmt_sel` with write-data bits 1:0 from the clock edge that takes the write.
- R5: Code 0x140 masks writes exactly as in R3, and `fmt_sel` stays 0 for every code other than 0x100.
- R6: For codes 0x178 and 0x182, a write changes only bit 7 of the display register.
- R7: For code 0x190, the display register reads as zero and writes have no effect.
- R8: For an unrecognised code, writes to the display register have no effect and it reads 0x0000_1F00.
- R9: A read of offset 0x48 returns card present in bit 0 and write protect in bit 2 (codes 0x100 and 0x140) or bit 1 (all other codes), with all other bits zero. Writes to 0x48 have no effect.
- R10: Each pin passes through two flops. A pin change is invisible to a read request sampled on the second rising edge after the change, and visible to one sampled on the third.
- R11: Read data appears in `bus_rdata` with `bus_rvalid` high for one cycle after the edge that samples a read request. Offsets other than 0x48 and 0x50 read as zero, and writes never raise `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Request valid for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| board_strap | input | 32 | Static board identity strap |
| card_present_pin | input | 1 | Asynchronous card-present pin |
| wprot_pin | input | 1 | Asynchronous write-protect pin |
| fmt_sel | output | 2 | Pixel-format selector |

## Verification
The board code is only sampled meaningfully across a reset, so the hardest state to reach is each variant's write masking on top of that variant's own reset value. The stimulus changes the strap while reset is held, releases reset, then writes and reads back, so that every variant is reached from its true starting point. Pin timing is the other awkward case. A pin is toggled on a falling edge, and reads are placed exactly on the second and third rising edges after it to show where the synchroniser boundary lies.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam int unsigned CODE_W = 12;

  localparam logic [CODE_W-1:0] CODE_MUXED = 12'h100;
  localparam logic [CODE_W-1:0] CODE_PLAIN = 12'h140;
  localparam logic [CODE_W-1:0] CODE_B7_A  = 12'h178;
  localparam logic [CODE_W-1:0] CODE_B7_B  = 12'h182;
  localparam logic [CODE_W-1:0] CODE_BLANK = 12'h190;

  typedef enum logic [2:0] {
    VAR_MUXED = 3'd0,
    VAR_PLAIN = 3'd1,
    VAR_BIT7  = 3'd2,
    VAR_BLANK = 3'd3,
    VAR_OTHER = 3'd4
  } variant_e;

  typedef struct packed {
    variant_e kind;
    logic     wp_high;
  } variant_t;

endpackage

// File: rtl/dcr_sync.sv
module dcr_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/dcr_variant_decode.sv
module dcr_variant_decode
  import dcr_pkg::*;
#(
  parameter int unsigned STRAP_W = 32,
  parameter int unsigned CODE_LSB = 16
) (
  input  logic [STRAP_W-1:0] board_strap,
  output variant_t           variant
);

  logic [CODE_W-1:0] code;
  assign code = board_strap[CODE_LSB +: CODE_W];

  always_comb begin
    variant.wp_high = 1'b0;
    unique case (code)
      CODE_MUXED: begin
        variant.kind    = VAR_MUXED;
        variant.wp_high = 1'b1;
      end
      CODE_PLAIN: begin
        variant.kind    = VAR_PLAIN;
        variant.wp_high = 1'b1;
      end
      CODE_B7_A, CODE_B7_B: variant.kind = VAR_BIT7;
      CODE_BLANK:           variant.kind = VAR_BLANK;
      default:              variant.kind = VAR_OTHER;
    endcase
  end

endmodule

// File: rtl/dcr_disp_reg.sv
module dcr_disp_reg
  import dcr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned RO_LSB    = 8,
  parameter int unsigned RO_MSB    = 13,
  parameter int unsigned ONE_BIT   = 7,
  parameter int unsigned ID_LSB    = 8,
  parameter int unsigned ID_W      = 5,
  parameter logic [ID_W-1:0] ID_VAL = 5'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  variant_t          variant,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] disp_q,
  output logic [SEL_W-1:0]  fmt_sel
);

  localparam logic [DATA_W-1:0] ONES    = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] RO_MASK = (ONES << RO_LSB) & ~(ONES << (RO_MSB + 1));
  localparam logic [DATA_W-1:0] B_MASK  = {{(DATA_W-1){1'b0}}, 1'b1} << ONE_BIT;
  localparam logic [DATA_W-1:0] RST_VAL = {{(DATA_W-ID_W){1'b0}}, ID_VAL} << ID_LSB;

  logic [DATA_W-1:0] disp_d;

  always_comb begin
    disp_d = disp_q;
    if (wr_en) begin
      case (variant.kind)
        VAR_MUXED, VAR_PLAIN: disp_d = (disp_q & RO_MASK) | (wdata & ~RO_MASK);
        VAR_BIT7:             disp_d = (disp_q & ~B_MASK) | (wdata & B_MASK);
        VAR_BLANK:            disp_d = '0;
        default:              disp_d = disp_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_q  <= (variant.kind == VAR_BLANK) ? '0 : RST_VAL;
      fmt_sel <= '0;
    end else begin
      disp_q <= disp_d;
      if (wr_en && variant.kind == VAR_MUXED) fmt_sel <= wdata[SEL_W-1:0];
    end
  end

  AST_RO_FIELD_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (variant.kind == VAR_MUXED || variant.kind == VAR_PLAIN))
      |=> ((disp_q & RO_MASK) == $past(disp_q & RO_MASK))); // R3
  AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && variant.kind == VAR_MUXED) |=> (fmt_sel == $past(wdata[SEL_W-1:0]))); // R4
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (variant.kind != VAR_MUXED) |-> (fmt_sel == '0)); // R5
  AST_ONE_BIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && variant.kind == VAR_BIT7) |=> ((disp_q & ~B_MASK) == $past(disp_q & ~B_MASK))); // R6
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (variant.kind == VAR_BLANK) |-> (disp_q == '0)); // R7
  AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (variant.kind == VAR_OTHER) |=> $stable(disp_q)); // R8

endmodule

// File: rtl/dcr_card_status.sv
module dcr_card_status
  import dcr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CD_BIT  = 0,
  parameter int unsigned WP_HIGH = 2,
  parameter int unsigned WP_LOW  = 1
) (
  input  variant_t          variant,
  input  logic              card_present,
  input  logic              wprot,
  output logic [DATA_W-1:0] status
);

  always_comb begin
    status         = '0;
    status[CD_BIT] = card_present;
    if (variant.wp_high) status[WP_HIGH] = wprot;
    else                 status[WP_LOW]  = wprot;
  end

endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
  import dcr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter logic [ADDR_W-1:0] DISP_OFS = 12'h050,
  parameter logic [ADDR_W-1:0] CARD_OFS = 12'h048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [31:0]       board_strap,
  input  logic              card_present_pin,
  input  logic              wprot_pin,
  output logic [SEL_W-1:0]  fmt_sel
);

  localparam int unsigned PIN_N = 2;
  localparam int unsigned CD_BIT  = 0;
  localparam int unsigned WP_HIGH = 2;
  localparam int unsigned WP_LOW  = 1;
  localparam logic [DATA_W-1:0] CARD_MASK =
    ({{(DATA_W-1){1'b0}}, 1'b1} << CD_BIT) |
    ({{(DATA_W-1){1'b0}}, 1'b1} << WP_HIGH) |
    ({{(DATA_W-1){1'b0}}, 1'b1} << WP_LOW);

  variant_t          variant;
  logic [PIN_N-1:0]  pins_sync;
  logic [DATA_W-1:0] disp_q;
  logic [DATA_W-1:0] card_word;
  logic [DATA_W-1:0] rd_next;
  logic              disp_wr;
  logic              rd_req;

  dcr_variant_decode #(.STRAP_W(32), .CODE_LSB(16)) u_decode (
    .board_strap(board_strap),
    .variant    (variant)
  );

  dcr_sync #(.WIDTH(PIN_N), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in({wprot_pin, card_present_pin}),
    .sync_out(pins_sync)
  );

  assign disp_wr = bus_sel && bus_wr && (bus_addr == DISP_OFS);
  assign rd_req  = bus_sel && !bus_wr;

  dcr_disp_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_disp (
    .clk    (clk),
    .rst    (rst),
    .variant(variant),
    .wr_en  (disp_wr),
    .wdata  (bus_wdata),
    .disp_q (disp_q),
    .fmt_sel(fmt_sel)
  );

  dcr_card_status #(.DATA_W(DATA_W), .CD_BIT(CD_BIT), .WP_HIGH(WP_HIGH), .WP_LOW(WP_LOW)) u_card (
    .variant     (variant),
    .card_present(pins_sync[0]),
    .wprot       (pins_sync[1]),
    .status      (card_word)
  );

  always_comb begin
    rd_next = '0;
    if (bus_addr == DISP_OFS)      rd_next = (variant.kind == VAR_BLANK) ? '0 : disp_q;
    else if (bus_addr == CARD_OFS) rd_next = card_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_next;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_sel && !bus_wr)); // R11
  AST_CARD_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == CARD_OFS) |-> ((bus_rdata & ~CARD_MASK) == '0)); // R9

endmodule

// File: tb/sim_disp_ctrl_regs.sv
module sim_disp_ctrl_regs;

  typedef struct packed {
    logic [11:0] code;
    logic [31:0] wdata;
    logic [31:0] exp_q;
    logic [1:0]  exp_sel;
  } vec_t;

  // R1 R3 R4 R5 R6 R7 R8: strap garbage outside 27:16 is added below
  localparam vec_t [0:7] VECS = '{
    '{12'h100, 32'hFFFF_FFFF, 32'hFFFF_DFFF, 2'd3},
    '{12'h100, 32'h0000_2A02, 32'h0000_1F02, 2'd2},
    '{12'h140, 32'h1234_5681, 32'h1234_5F81, 2'd0},
    '{12'h178, 32'hFFFF_FFFF, 32'h0000_1F80, 2'd0},
    '{12'h182, 32'h0000_007F, 32'h0000_1F00, 2'd0},
    '{12'h190, 32'hFFFF_FFFF, 32'h0000_0000, 2'd0},
    '{12'h101, 32'hFFFF_FFFF, 32'h0000_1F00, 2'd0},
    '{12'h0AB, 32'h0000_0000, 32'h0000_1F00, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] board_strap = '0;
  logic        card_present_pin = 1'b0;
  logic        wprot_pin = 1'b0;
  logic [1:0]  fmt_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  disp_ctrl_regs u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .board_strap(board_strap), .card_present_pin(card_present_pin),
    .wprot_pin(wprot_pin), .fmt_sel(fmt_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [11:0] code);
    @(negedge clk);
    rst = 1'b1;
    board_strap = 32'hA000_5A5A | ({20'd0, code} << 16);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
    v = bus_rvalid;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic        v;

    // vector table walk
    for (int i = 0; i < 8; i++) begin
      apply_reset(VECS[i].code);
      bus_write(12'h050, VECS[i].wdata);
      check("R4/R5 fmt_sel after write", {30'd0, fmt_sel}, {30'd0, VECS[i].exp_sel});
      check("R11 no rvalid on write", {31'd0, bus_rvalid}, 32'd0);
      bus_read(12'h050, d, v);
      check("R3/R6/R7/R8 display readback", d, VECS[i].exp_q);
    end

    // R2 reset state
    apply_reset(12'h100);
    check("R2 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
    check("R2 fmt_sel after reset", {30'd0, fmt_sel}, 32'd0);
    bus_read(12'h050, d, v);
    check("R2 reset value", d, 32'h0000_1F00);
    check("R11 rvalid after read", {31'd0, v}, 32'd1);
    @(negedge clk);
    check("R11 rvalid single cycle", {31'd0, bus_rvalid}, 32'd0);
    apply_reset(12'h190);
    bus_read(12'h050, d, v);
    check("R2 blank reset value", d, 32'd0);

    // R6 bit 7 can be cleared again
    apply_reset(12'h182);
    bus_write(12'h050, 32'h0000_0080);
    bus_write(12'h050, 32'hFFFF_FF7F);
    bus_read(12'h050, d, v);
    check("R6 bit 7 cleared, rest held", d, 32'h0000_1F00);

    // R4 selector follows successive writes on 0x100
    apply_reset(12'h100);
    bus_write(12'h050, 32'h0000_0001);
    check("R4 selector 1", {30'd0, fmt_sel}, 32'd1);
    bus_write(12'h050, 32'h0000_3F00);
    check("R4 selector 0", {30'd0, fmt_sel}, 32'd0);
    bus_read(12'h050, d, v);
    check("R3 read-only field kept", d, 32'h0000_1F00);

    // R9 card status placement
    card_present_pin = 1'b1; wprot_pin = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(12'h048, d, v);
    check("R9 code 0x100 wp at bit 2", d, 32'h0000_0005);
    bus_write(12'h048, 32'hFFFF_FFFF);
    bus_read(12'h048, d, v);
    check("R9 card write ignored", d, 32'h0000_0005);
    apply_reset(12'h182);
    repeat (3) @(negedge clk);
    bus_read(12'h048, d, v);
    check("R9 code 0x182 wp at bit 1", d, 32'h0000_0003);
    apply_reset(12'h0AB);
    repeat (3) @(negedge clk);
    bus_read(12'h048, d, v);
    check("R9 unknown code wp at bit 1", d, 32'h0000_0003);
    apply_reset(12'h140);
    card_present_pin = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(12'h048, d, v);
    check("R9 code 0x140 wp only", d, 32'h0000_0004);

    // R10 synchroniser boundary
    card_present_pin = 1'b1;
    @(negedge clk);
    bus_read(12'h048, d, v);
    check("R10 second edge still old", d, 32'h0000_0004);
    bus_read(12'h048, d, v);
    check("R10 third edge shows new", d, 32'h0000_0005);

    // R11 undecoded offset
    bus_read(12'h04C, d, v);
    check("R11 undecoded reads zero", d, 32'd0);

    finish_run();
  end

endmodule